// File: doc/BRIEF.md
# PCI Host Configuration Access Unit

This unit lets a master on the internal register bus reach the configuration space of devices on a PCI segment. Software first writes a selector word naming bus, device, function and dword register. A later read or write of the data window turns into one configuration transaction toward a PCI transaction engine. Whether that transaction is Type 0 or Type 1 follows from the bus number in the selector.

Cycles are only launched when the controller is strapped as host and the selector's enable bit is set. Otherwise, data window accesses complete locally and touch nothing. During device enumeration, empty slots leave transactions unclaimed. After a fixed claim window the unit abandons the transaction. A control bit then decides whether an abandoned read reports a bus error or quietly returns all ones. Abandoned writes always complete quietly.

Top module: `cfg_access_unit`

## Requirements
- R1: After reset, `reg_ack_o` and `eng_req_o` are low, the selector reads 0 and the control register reads 1 (bus error on unclaimed reads enabled).
- R2: Register offsets: 0 selects the selector, 1 the data window, 2 the control register (bit 0 = error-on-unclaimed-read). The selector keeps only bit 31 (enable), [23:16] bus, [15:11] device, [10:8] function and [7:2] register; every other bit reads back 0. Selector and control accesses are acknowledged one cycle after the request. Writes return read data 0.
- R3: With host mode and enable set, a data window access raises `eng_req_o` the cycle after the request, with `eng_we_o` equal to the access direction and, for writes, `eng_wdata_o` equal to the written word. The request and its address stay stable while it is held.
- R4: A selector with bus 0 gives a Type 0 address: bits [15:2] carry device, function and register, all other bits 0, and [1:0] = 00.
- R5: A selector with a nonzero bus gives a Type 1 address: [23:16] bus, [15:11] device, [10:8] function, [7:2] register, [31:24] zero, and [1:0] = 01.
- R6: With host mode low, a data window access starts no transaction; it is acknowledged the next cycle, reads return 32'hFFFF_FFFF and writes are discarded.
- R7: With the selector enable bit clear, a data window access behaves exactly as in R6.
- R8: For a claimed read, the engine's `eng_rdata_i` on the `eng_done_i` cycle appears on `reg_rdata_o` with `reg_ack_o` one cycle later and `reg_err_o` low.
- R9: The engine may claim in any of the first TIMEOUT cycles of the request (default 5). A claim in the last of these cycles is accepted. Without a claim, `eng_req_o` is held exactly TIMEOUT cycles and then dropped.
- R10: An unclaimed read with the control bit set completes with `reg_err_o` high and read data 0.
- R11: An unclaimed read with the control bit clear completes with `reg_err_o` low and read data 32'hFFFF_FFFF.
- R12: An unclaimed write completes with `reg_err_o` low, whatever the control bit.
- R13: `reg_ack_o` is a single-cycle pulse, one per request, and is never high while `eng_req_o` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| host_mode_i | input | 1 | Controller operates as PCI host |
| reg_req_i | input | 1 | One-cycle register access request |
| reg_we_i | input | 1 | Access is a write |
| reg_addr_i | input | 2 | Register offset |
| reg_wdata_i | input | 32 | Write data |
| reg_ack_o | output | 1 | Access completion pulse |
| reg_rdata_o | output | 32 | Read data, valid with ack |
| reg_err_o | output | 1 | Bus error, valid with ack |
| eng_req_o | output | 1 | Configuration transaction request |
| eng_we_o | output | 1 | Transaction is a configuration write |
| eng_addr_o | output | 32 | Configuration address with type bits |
| eng_wdata_o | output | 32 | Configuration write data |
| eng_claim_i | input | 1 | A device claimed the transaction |
| eng_done_i | input | 1 | Data phase finished |
| eng_rdata_i | input | 32 | Configuration read data |

## Verification
A corrupted selector register shows up on the very first engine request as a wrong address or wrong type bits. It also appears one cycle after any selector read. A sequencer stuck or off by one in its claim window shows as a request held one cycle too long or too short, as an accepted late claim, or as an acknowledge overlapping the request. These are visible within TIMEOUT+1 cycles of the data window access. A lost or flipped control bit appears only on the next unclaimed read, as a wrong error flag paired with the wrong data pattern.

// File: rtl/cfg_access_pkg.sv
`timescale 1ns/1ps
package cfg_access_pkg;

    localparam int DW     = 32;
    localparam int BUS_W  = 8;
    localparam int DEV_W  = 5;
    localparam int FN_W   = 3;
    localparam int REGN_W = 6;

    // selector field positions
    localparam int SEL_EN_B   = 31;
    localparam int SEL_BUS_LO = 16;
    localparam int SEL_DEV_LO = 11;
    localparam int SEL_FN_LO  = 8;
    localparam int SEL_REG_LO = 2;

    localparam logic [DW-1:0] SEL_KEEP = 32'h80FF_FFFC;
    localparam logic [DW-1:0] ALL_ONES = '1;

    localparam logic [1:0] OFS_SEL  = 2'd0;
    localparam logic [1:0] OFS_DATA = 2'd1;
    localparam logic [1:0] OFS_CTRL = 2'd2;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_DATA  = 2'd2
    } cfg_state_e;

    typedef struct packed {
        cfg_state_e     st;
        logic [DW-1:0]  sel;
        logic           err_on_miss;
        logic           xfer_we;
        logic [DW-1:0]  xfer_wdata;
        logic           ack;
        logic           err;
        logic [DW-1:0]  rdata;
    } cfg_regs_t;

endpackage

// File: rtl/cfg_addr_encode.sv
`timescale 1ns/1ps
module cfg_addr_encode
    import cfg_access_pkg::*;
(
    input  logic [BUS_W-1:0]  bus_i,
    input  logic [DEV_W-1:0]  dev_i,
    input  logic [FN_W-1:0]   fn_i,
    input  logic [REGN_W-1:0] regn_i,
    output logic [DW-1:0]     addr_o
);
    localparam int UPPER_W = DW - SEL_BUS_LO - BUS_W;

    logic type1;

    always_comb begin
        type1  = (bus_i != '0);
        addr_o = '0;
        addr_o[SEL_DEV_LO +: DEV_W]  = dev_i;
        addr_o[SEL_FN_LO  +: FN_W]   = fn_i;
        addr_o[SEL_REG_LO +: REGN_W] = regn_i;
        addr_o[DW-1 -: UPPER_W]      = '0;
        if (type1) begin
            addr_o[SEL_BUS_LO +: BUS_W] = bus_i;
            addr_o[1:0]                 = 2'b01;
        end else begin
            addr_o[1:0]                 = 2'b00;
        end
    end
endmodule

// File: rtl/cfg_noresp_timer.sv
`timescale 1ns/1ps
module cfg_noresp_timer #(
    parameter int TIMEOUT = 5
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic run_i,
    output logic expired_o
);
    localparam int CW = (TIMEOUT > 1) ? $clog2(TIMEOUT) : 1;
    localparam logic [CW-1:0] LAST = CW'(TIMEOUT - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d     = cnt_q;
        expired_o = run_i && (cnt_q == LAST);
        if (!run_i || expired_o) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/cfg_access_unit.sv
`timescale 1ns/1ps
module cfg_access_unit
    import cfg_access_pkg::*;
#(
    parameter int TIMEOUT = 5
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          host_mode_i,
    input  logic          reg_req_i,
    input  logic          reg_we_i,
    input  logic [1:0]    reg_addr_i,
    input  logic [31:0]   reg_wdata_i,
    output logic          reg_ack_o,
    output logic [31:0]   reg_rdata_o,
    output logic          reg_err_o,
    output logic          eng_req_o,
    output logic          eng_we_o,
    output logic [31:0]   eng_addr_o,
    output logic [31:0]   eng_wdata_o,
    input  logic          eng_claim_i,
    input  logic          eng_done_i,
    input  logic [31:0]   eng_rdata_i
);
    cfg_regs_t cur_q, nx_d;
    logic      timer_run;
    logic      timer_expired;
    logic      launch_ok;

    assign timer_run = (cur_q.st == ST_ISSUE);

    cfg_noresp_timer #(.TIMEOUT(TIMEOUT)) u_timer (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .run_i     (timer_run),
        .expired_o (timer_expired)
    );

    cfg_addr_encode u_enc (
        .bus_i  (cur_q.sel[SEL_BUS_LO +: BUS_W]),
        .dev_i  (cur_q.sel[SEL_DEV_LO +: DEV_W]),
        .fn_i   (cur_q.sel[SEL_FN_LO  +: FN_W]),
        .regn_i (cur_q.sel[SEL_REG_LO +: REGN_W]),
        .addr_o (eng_addr_o)
    );

    always_comb begin
        nx_d      = cur_q;
        nx_d.ack  = 1'b0;
        nx_d.err  = 1'b0;
        launch_ok = host_mode_i && cur_q.sel[SEL_EN_B];

        unique case (cur_q.st)
            ST_IDLE: begin
                if (reg_req_i) begin
                    nx_d.rdata = '0;
                    case (reg_addr_i)
                        OFS_SEL: begin
                            nx_d.ack = 1'b1;
                            if (reg_we_i) nx_d.sel = reg_wdata_i & SEL_KEEP;
                            else          nx_d.rdata = cur_q.sel;
                        end
                        OFS_CTRL: begin
                            nx_d.ack = 1'b1;
                            if (reg_we_i) nx_d.err_on_miss = reg_wdata_i[0];
                            else          nx_d.rdata = {{(DW-1){1'b0}}, cur_q.err_on_miss};
                        end
                        OFS_DATA: begin
                            if (launch_ok) begin
                                nx_d.st         = ST_ISSUE;
                                nx_d.xfer_we    = reg_we_i;
                                nx_d.xfer_wdata = reg_wdata_i;
                            end else begin
                                nx_d.ack = 1'b1;
                                if (!reg_we_i) nx_d.rdata = ALL_ONES;
                            end
                        end
                        default: begin
                            nx_d.ack = 1'b1;
                        end
                    endcase
                end
            end
            ST_ISSUE: begin
                if (eng_claim_i) begin
                    nx_d.st = ST_DATA;
                end else if (timer_expired) begin
                    nx_d.st  = ST_IDLE;
                    nx_d.ack = 1'b1;
                    if (cur_q.xfer_we) begin
                        nx_d.rdata = '0;
                    end else if (cur_q.err_on_miss) begin
                        nx_d.err   = 1'b1;
                        nx_d.rdata = '0;
                    end else begin
                        nx_d.rdata = ALL_ONES;
                    end
                end
            end
            ST_DATA: begin
                if (eng_done_i) begin
                    nx_d.st    = ST_IDLE;
                    nx_d.ack   = 1'b1;
                    nx_d.rdata = cur_q.xfer_we ? '0 : eng_rdata_i;
                end
            end
            default: begin
                nx_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cur_q             <= '0;
            cur_q.err_on_miss <= 1'b1;
        end else begin
            cur_q <= nx_d;
        end
    end

    assign reg_ack_o   = cur_q.ack;
    assign reg_rdata_o = cur_q.rdata;
    assign reg_err_o   = cur_q.err;
    assign eng_req_o   = (cur_q.st != ST_IDLE);
    assign eng_we_o    = cur_q.xfer_we;
    assign eng_wdata_o = cur_q.xfer_wdata;

endmodule

// File: rtl/cfg_access_checker.sv
`timescale 1ns/1ps
module cfg_access_checker #(
    parameter int TIMEOUT = 5
) (
    input logic        clk_i,
    input logic        rst_ni,
    input logic        host_mode_i,
    input logic        reg_ack_o,
    input logic        reg_err_o,
    input logic        eng_req_o,
    input logic        eng_we_o,
    input logic [31:0] eng_addr_o,
    input logic        eng_claim_i
);
    int   wait_q;
    logic seen_q;

    always_ff @(posedge clk_i) begin
        if (!rst_ni || !eng_req_o) begin
            wait_q <= 0;
            seen_q <= 1'b0;
        end else if (eng_claim_i) begin
            seen_q <= 1'b1;
        end else if (!seen_q) begin
            wait_q <= wait_q + 1;
        end
    end

    p_ack_pulse_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
        reg_ack_o |=> !reg_ack_o);

    p_ack_idle_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
        reg_ack_o |-> !eng_req_o);

    p_host_only_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(eng_req_o) |-> $past(host_mode_i));

    p_err_with_ack_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        reg_err_o |-> reg_ack_o);

    p_addr_stable_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (eng_req_o && $past(eng_req_o)) |-> $stable(eng_addr_o));

    p_type_low_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        eng_req_o |-> (eng_addr_o[1] == 1'b0));

    p_type_sel_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        eng_req_o |-> ((eng_addr_o[0] == (eng_addr_o[23:16] != 8'd0))
                       && (eng_addr_o[31:24] == 8'd0)));

    p_claim_window_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (eng_req_o && !seen_q) |-> (wait_q < TIMEOUT));

    p_write_no_err_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($fell(eng_req_o) && $past(eng_we_o)) |-> !reg_err_o);

endmodule

bind cfg_access_unit cfg_access_checker #(.TIMEOUT(TIMEOUT)) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .host_mode_i (host_mode_i),
    .reg_ack_o   (reg_ack_o),
    .reg_err_o   (reg_err_o),
    .eng_req_o   (eng_req_o),
    .eng_we_o    (eng_we_o),
    .eng_addr_o  (eng_addr_o),
    .eng_claim_i (eng_claim_i)
);

// File: tb/cfg_access_unit_bench.sv
`timescale 1ns/1ps
module cfg_access_unit_bench;

    localparam int TO = 5;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        host_mode;
    logic        reg_req, reg_we;
    logic [1:0]  reg_addr;
    logic [31:0] reg_wdata;
    logic        reg_ack, reg_err;
    logic [31:0] reg_rdata;
    logic        eng_req, eng_we;
    logic [31:0] eng_addr, eng_wdata;
    logic        eng_claim, eng_done;
    logic [31:0] eng_rdata;

    always #4 clk = ~clk;

    cfg_access_unit #(.TIMEOUT(TO)) u_cfg_access_unit (
        .clk_i(clk), .rst_ni(rst_n), .host_mode_i(host_mode),
        .reg_req_i(reg_req), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
        .reg_wdata_i(reg_wdata), .reg_ack_o(reg_ack), .reg_rdata_o(reg_rdata),
        .reg_err_o(reg_err), .eng_req_o(eng_req), .eng_we_o(eng_we),
        .eng_addr_o(eng_addr), .eng_wdata_o(eng_wdata), .eng_claim_i(eng_claim),
        .eng_done_i(eng_done), .eng_rdata_i(eng_rdata)
    );

    typedef struct {
        logic [31:0] rdata;
        logic        err;
        string       tag;
    } rsp_item_t;

    typedef struct {
        logic        we;
        logic [31:0] addr;
        logic [31:0] wdata;
        int          claim_dly;
        logic [31:0] rdata;
        string       tag;
    } eng_item_t;

    rsp_item_t rsp_q[$];
    eng_item_t eng_q[$];
    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int req_cyc = 0;
    bit finished = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    function automatic logic [31:0] sel_word(input bit en, input int bus, input int dev,
                                             input int fn, input int rg);
        return {en, 7'd0, 8'(bus), 5'(dev), 3'(fn), 6'(rg), 2'b00};
    endfunction

    function automatic logic [31:0] cfg_addr(input int bus, input int dev,
                                             input int fn, input int rg);
        if (bus == 0) return {16'd0, 5'(dev), 3'(fn), 6'(rg), 2'b00};
        return {8'd0, 8'(bus), 5'(dev), 3'(fn), 6'(rg), 2'b01};
    endfunction

    task automatic expect_cycle(input bit we, input logic [31:0] addr, input logic [31:0] wd,
                                input int dly, input logic [31:0] rd, input string tag);
        eng_item_t e;
        e.we = we; e.addr = addr; e.wdata = wd; e.claim_dly = dly; e.rdata = rd; e.tag = tag;
        eng_q.push_back(e);
    endtask

    task automatic access(input bit we, input logic [1:0] ofs, input logic [31:0] wd,
                          input logic [31:0] exp_rd, input bit exp_err, input string tag);
        rsp_item_t r;
        r.rdata = exp_rd; r.err = exp_err; r.tag = tag;
        @(negedge clk);
        rsp_q.push_back(r);
        reg_req = 1'b1; reg_we = we; reg_addr = ofs; reg_wdata = wd;
        req_cyc = cyc;
        @(negedge clk);
        reg_req = 1'b0;
        while (rsp_q.size() != 0) @(negedge clk);
    endtask

    // monitor: pops expected responses as acks appear
    always @(negedge clk) begin
        rsp_item_t r;
        if (rst_n && reg_ack) begin
            check(!eng_req, "R13", "eng_req during ack", 32'(eng_req), 32'd0);
            if (rsp_q.size() == 0) begin
                check(1'b0, "R13", "ack without request", 32'd1, 32'd0);
            end else begin
                r = rsp_q.pop_front();
                check(reg_rdata == r.rdata, r.tag, "read data", reg_rdata, r.rdata);
                check(reg_err == r.err, r.tag, "error flag", 32'(reg_err), 32'(r.err));
            end
        end
    end

    // PCI engine model
    initial begin
        eng_item_t e;
        int n;
        eng_claim = 1'b0; eng_done = 1'b0; eng_rdata = '0;
        forever begin
            @(negedge clk);
            if (rst_n && eng_req) begin
                if (eng_q.size() == 0) begin
                    check(1'b0, "R6", "unexpected transaction", eng_addr, 32'd0);
                    while (eng_req) @(negedge clk);
                end else begin
                    e = eng_q.pop_front();
                    check(cyc == req_cyc + 1, "R3", "start latency", 32'(cyc), 32'(req_cyc + 1));
                    check(eng_addr == e.addr, e.tag, "config address", eng_addr, e.addr);
                    check(eng_we == e.we, "R3", "direction", 32'(eng_we), 32'(e.we));
                    if (e.we) check(eng_wdata == e.wdata, "R3", "write data", eng_wdata, e.wdata);
                    if (e.claim_dly < 0) begin
                        n = 0;
                        while (eng_req) begin
                            n++;
                            @(negedge clk);
                        end
                        check(n == TO, "R9", "unclaimed request length", 32'(n), 32'(TO));
                    end else begin
                        repeat (e.claim_dly) @(negedge clk);
                        eng_claim = 1'b1;
                        @(negedge clk);
                        eng_claim = 1'b0;
                        eng_done  = 1'b1;
                        eng_rdata = e.rdata;
                        @(negedge clk);
                        eng_done  = 1'b0;
                    end
                end
            end
        end
    end

    initial begin
        #(8 * 100000);
        check(1'b0, "R1", "watchdog expired", 32'd0, 32'd1);
        report();
    end

    initial begin
        logic [31:0] w;
        rst_n = 1'b0; host_mode = 1'b0;
        reg_req = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(reg_ack == 1'b0, "R1", "ack after reset", 32'(reg_ack), 32'd0);
        check(eng_req == 1'b0, "R1", "eng_req after reset", 32'(eng_req), 32'd0);
        access(1'b0, 2'd0, 32'd0, 32'd0, 1'b0, "R1");
        access(1'b0, 2'd2, 32'd0, 32'd1, 1'b0, "R1");

        // R2 masking and readback
        access(1'b1, 2'd0, 32'hFFFF_FFFF, 32'd0, 1'b0, "R2");
        access(1'b0, 2'd0, 32'd0, 32'h80FF_FFFC, 1'b0, "R2");
        access(1'b0, 2'd3, 32'd0, 32'd0, 1'b0, "R2");

        host_mode = 1'b1;
        // R4 / R8: Type 0 claimed read
        w = sel_word(1, 0, 3, 2, 16);
        access(1'b1, 2'd0, w, 32'd0, 1'b0, "R2");
        expect_cycle(1'b0, cfg_addr(0, 3, 2, 16), 32'd0, 0, 32'h1234_5678, "R4");
        access(1'b0, 2'd1, 32'd0, 32'h1234_5678, 1'b0, "R8");

        // R5 / R3: Type 1 claimed write
        w = sel_word(1, 5, 31, 7, 63);
        access(1'b1, 2'd0, w, 32'd0, 1'b0, "R2");
        expect_cycle(1'b1, cfg_addr(5, 31, 7, 63), 32'hCAFE_F00D, 2, 32'd0, "R5");
        access(1'b1, 2'd1, 32'hCAFE_F00D, 32'd0, 1'b0, "R3");

        // R9: claim in the last cycle of the window
        expect_cycle(1'b0, cfg_addr(5, 31, 7, 63), 32'd0, TO - 1, 32'hA5A5_0001, "R9");
        access(1'b0, 2'd1, 32'd0, 32'hA5A5_0001, 1'b0, "R9");

        // R10: unclaimed read, error enabled
        expect_cycle(1'b0, cfg_addr(5, 31, 7, 63), 32'd0, -1, 32'd0, "R9");
        access(1'b0, 2'd1, 32'd0, 32'd0, 1'b1, "R10");

        // R12: unclaimed write, error enabled
        expect_cycle(1'b1, cfg_addr(5, 31, 7, 63), 32'h0000_1111, -1, 32'd0, "R12");
        access(1'b1, 2'd1, 32'h0000_1111, 32'd0, 1'b0, "R12");

        // R11: control bit cleared
        access(1'b1, 2'd2, 32'd0, 32'd0, 1'b0, "R11");
        access(1'b0, 2'd2, 32'd0, 32'd0, 1'b0, "R11");
        expect_cycle(1'b0, cfg_addr(5, 31, 7, 63), 32'd0, -1, 32'd0, "R11");
        access(1'b0, 2'd1, 32'd0, 32'hFFFF_FFFF, 1'b0, "R11");
        expect_cycle(1'b1, cfg_addr(5, 31, 7, 63), 32'h0000_2222, -1, 32'd0, "R12");
        access(1'b1, 2'd1, 32'h0000_2222, 32'd0, 1'b0, "R12");

        // R7: enable clear starts nothing
        w = sel_word(0, 5, 31, 7, 63);
        access(1'b1, 2'd0, w, 32'd0, 1'b0, "R7");
        access(1'b0, 2'd1, 32'd0, 32'hFFFF_FFFF, 1'b0, "R7");
        access(1'b1, 2'd1, 32'h3333_3333, 32'd0, 1'b0, "R7");

        // R6: not host starts nothing
        w = sel_word(1, 0, 9, 1, 4);
        access(1'b1, 2'd0, w, 32'd0, 1'b0, "R6");
        host_mode = 1'b0;
        access(1'b0, 2'd1, 32'd0, 32'hFFFF_FFFF, 1'b0, "R6");
        access(1'b1, 2'd1, 32'h4444_4444, 32'd0, 1'b0, "R6");

        // back to host: a fresh Type 0 read works
        host_mode = 1'b1;
        expect_cycle(1'b0, cfg_addr(0, 9, 1, 4), 32'd0, 1, 32'h0BAD_CAFE, "R4");
        access(1'b0, 2'd1, 32'd0, 32'h0BAD_CAFE, 1'b0, "R8");

        repeat (10) @(negedge clk);
        check(eng_q.size() == 0, "R3", "expected transactions left", 32'(eng_q.size()), 32'd0);
        check(rsp_q.size() == 0, "R13", "responses left", 32'(rsp_q.size()), 32'd0);
        report();
    end

endmodule